// File: doc/BRIEF.md
# Three-Channel Timer Counter Unit

The unit holds three independent 16-bit timer channels behind one 32-bit register port with single-cycle read and write strobes. Each channel counts up or down, one step per prescaled clock, and wraps either at a programmable interval value or over the full 16-bit range. Three comparators per channel flag when the count lands on a programmed value. Wraps and matches latch into a six-bit status register that clears when read. Each channel drives its own interrupt line, gated by a per-bit enable mask.

The register words of the three channels are interleaved. Each register kind takes a 12-byte group, and channel i sits at byte +4*i inside that group. Software sets the prescaler, direction, wrap mode and compare values while the channel is stopped, clears the count with a self-clearing command bit, and then starts the channel. It reads the status register from its interrupt handler.

Top module: `tri_timer_unit`

## Requirements
- R1: The clock control word holds the prescaler enable in bit 0 and a select value N in bits 4:1. With the enable set, the count steps once every 2^(N+1) clocks, with the first step 2^(N+1)-1 clocks after a clock control write and one step every 2^(N+1) clocks after that. With the enable clear, it steps on every clock.
- R2: Counter control bit 0 stops the count, bit 1 selects interval wrap, bit 2 selects down counting and bit 3 enables the comparators. While bit 0 is set the count holds its value.
- R3: After reset, counter control reads 0x21, so every channel starts stopped. The count, status and interrupt outputs are 0.
- R4: Writing counter control with bit 4 set zeroes the count on that edge. Bit 4 is never stored and always reads 0.
- R5: Counting up, the count steps to 0 after reaching the limit. Counting down, it steps from 0 to the limit. The limit is the interval value in interval mode and 0xFFFF otherwise.
- R6: A wrap sets status bit 0 in interval mode and status bit 4 otherwise. Status bit 5 stays 0.
- R7: With bit 3 of counter control set, a step that lands on compare value k (k = 1..3) sets status bit k. A compare value above the current limit never fires.
- R8: Reading the status word returns it and clears it on the same edge, but an event on that same edge stays set. Writes to the status word have no effect.
- R9: A channel's interrupt output is high exactly when status AND enable is nonzero.
- R10: Register groups per channel, as byte offset + 4*channel: clock control 0x00, counter control 0x0C, count 0x18, interval 0x24, compare 1/2/3 at 0x30/0x3C/0x48, status 0x54, enable 0x60, event control 0x6C, event count 0x78. Clock control, counter control and enable keep 6 bits. Interval and compare keep 16 bits. Event control keeps 3 bits.
- R11: The count word is read-only and zero-extended. The event count word, misaligned addresses and addresses past the map read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; clears status when status is addressed |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of rd_en |
| irq | output | 3 | Interrupt line per channel |

## Verification
Random trials pick a channel, direction, wrap mode, interval and compare values and a run length. Each trial checks the final count and the accumulated status against a stepping model in the bench. Down runs from zero separate a wrap to the limit from a plain decrement. Short intervals separate interval wraps from overflow wraps. Directed cases cover a prescaled run whose step count depends on the divider phase, a compare value above the limit that must stay silent, an interval of zero that wraps on every step so that a coincident read and event show the new event surviving, and readbacks of masks, unmapped words and the read-only count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int CNT_W     = 16;
    parameter int NUM_MATCH = 3;
    parameter int CTL_W     = 6;
    parameter int ST_W      = 6;
    parameter int EVC_W     = 3;
    parameter int SEL_W     = 4;
    parameter int GRP_W     = 4;
    parameter int NUM_GRP   = 11;

    // register groups in address order (one word per channel each)
    typedef enum logic [GRP_W-1:0] {
        G_CLK   = 4'd0,
        G_CTRL  = 4'd1,
        G_COUNT = 4'd2,
        G_INTV  = 4'd3,
        G_M0    = 4'd4,
        G_M1    = 4'd5,
        G_M2    = 4'd6,
        G_STAT  = 4'd7,
        G_IEN   = 4'd8,
        G_EVC   = 4'd9,
        G_EVN   = 4'd10
    } grp_e;

    // counter control bits
    localparam int CC_DIS = 0;
    localparam int CC_INT = 1;
    localparam int CC_DEC = 2;
    localparam int CC_MEN = 3;
    localparam int CC_CLR = 4;

    // status bits
    localparam int ST_IVL = 0;
    localparam int ST_M0  = 1;
    localparam int ST_OVF = 4;

    localparam logic [CTL_W-1:0] CTRL_RST = 6'h21;

    typedef struct packed {
        logic [CTL_W-1:0]                clk_ctrl;
        logic [CTL_W-1:0]                cnt_ctrl;
        logic [CNT_W-1:0]                count;
        logic [CNT_W-1:0]                interval;
        logic [NUM_MATCH-1:0][CNT_W-1:0] match;
        logic [ST_W-1:0]                 status;
        logic [ST_W-1:0]                 ien;
        logic [EVC_W-1:0]                evctl;
    } chan_state_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = 2 ** SEL_W;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask  = DIV_W'((33'd2 << sel) - 33'd1);
        tick  = en ? ((div_q & mask) == mask) : 1'b1;
        div_d = clr ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R1: the divider restarts on a clock control write, so no step follows at once
    a_r1_no_tick_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!en || !tick));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [GRP_W-1:0] grp,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             irq
);
    chan_state_t st_d, st_q;

    logic             tick;
    logic             clk_wr;
    logic             rd_status;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_next;
    logic             wrap_ev;
    logic [ST_W-1:0]  ev;

    assign clk_wr    = wr_en && (grp == G_CLK);
    assign rd_status = rd_en && (grp == G_STAT);

    tmr_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clk_wr),
        .en    (st_q.clk_ctrl[0]),
        .sel   (st_q.clk_ctrl[SEL_W:1]),
        .tick  (tick)
    );

    always_comb begin
        st_d     = st_q;
        limit    = st_q.cnt_ctrl[CC_INT] ? st_q.interval : {CNT_W{1'b1}};
        cnt_next = st_q.count;
        wrap_ev  = 1'b0;
        ev       = '0;

        if (!st_q.cnt_ctrl[CC_DIS] && tick) begin
            if (st_q.cnt_ctrl[CC_DEC]) begin
                if (st_q.count == '0) begin
                    cnt_next = limit;
                    wrap_ev  = 1'b1;
                end else begin
                    cnt_next = st_q.count - 1'b1;
                end
            end else begin
                if (st_q.count >= limit) begin
                    cnt_next = '0;
                    wrap_ev  = 1'b1;
                end else begin
                    cnt_next = st_q.count + 1'b1;
                end
            end
            for (int i = 0; i < NUM_MATCH; i++) begin
                if (st_q.cnt_ctrl[CC_MEN] && (cnt_next == st_q.match[i])
                    && (st_q.match[i] <= limit))
                    ev[ST_M0+i] = 1'b1;
            end
        end

        ev[ST_IVL] = wrap_ev && st_q.cnt_ctrl[CC_INT];
        ev[ST_OVF] = wrap_ev && !st_q.cnt_ctrl[CC_INT];

        st_d.count  = cnt_next;
        st_d.status = (rd_status ? '0 : st_q.status) | ev;

        if (wr_en) begin
            case (grp)
                G_CLK:  st_d.clk_ctrl = wdata[CTL_W-1:0];
                G_CTRL: begin
                    st_d.cnt_ctrl = wdata[CTL_W-1:0] & ~(CTL_W'(1) << CC_CLR);
                    if (wdata[CC_CLR]) st_d.count = '0;
                end
                G_INTV: st_d.interval = wdata[CNT_W-1:0];
                G_M0:   st_d.match[0] = wdata[CNT_W-1:0];
                G_M1:   st_d.match[1] = wdata[CNT_W-1:0];
                G_M2:   st_d.match[2] = wdata[CNT_W-1:0];
                G_IEN:  st_d.ien      = wdata[ST_W-1:0];
                G_EVC:  st_d.evctl    = wdata[EVC_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (grp)
            G_CLK:   rdata[CTL_W-1:0] = st_q.clk_ctrl;
            G_CTRL:  rdata[CTL_W-1:0] = st_q.cnt_ctrl;
            G_COUNT: rdata[CNT_W-1:0] = st_q.count;
            G_INTV:  rdata[CNT_W-1:0] = st_q.interval;
            G_M0:    rdata[CNT_W-1:0] = st_q.match[0];
            G_M1:    rdata[CNT_W-1:0] = st_q.match[1];
            G_M2:    rdata[CNT_W-1:0] = st_q.match[2];
            G_STAT:  rdata[ST_W-1:0]  = st_q.status;
            G_IEN:   rdata[ST_W-1:0]  = st_q.ien;
            G_EVC:   rdata[EVC_W-1:0] = st_q.evctl;
            default: rdata = '0;
        endcase
    end

    assign irq = |(st_q.status & st_q.ien);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cnt_ctrl <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a stopped channel holds its count
    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt_ctrl[CC_DIS] && !wr_en) |=> $stable(st_q.count));

    // R4: the clear command zeroes the count on its edge
    a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && grp == G_CTRL && wdata[CC_CLR]) |=> (st_q.count == '0));

    // R5: in interval mode the count never leaves 0..interval
    a_r5_interval_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && st_q.cnt_ctrl[CC_INT] && st_q.count <= st_q.interval)
        |=> (st_q.count <= st_q.interval));

    // R8: a status read with no possible event leaves status empty
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && st_q.cnt_ctrl[CC_DIS]) |=> (st_q.status == '0));

    // R9: with nothing enabled the interrupt stays low
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ien == '0) |-> !irq);
endmodule

// File: rtl/tri_timer_unit.sv
module tri_timer_unit
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic [GRP_W-1:0]  grp;
    logic [CH_W-1:0]   ch_idx;
    logic              hit;
    logic [31:0]       ch_rdata [NUM_CH];

    always_comb begin
        word   = addr[ADDR_W-1:2];
        grp    = GRP_W'(32'(word) / NUM_CH);
        ch_idx = CH_W'(32'(word) % NUM_CH);
        hit    = (addr[1:0] == 2'b00) && (32'(word) < 32'(NUM_GRP * NUM_CH));
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = hit && (ch_idx == CH_W'(i));
        tmr_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en && sel),
            .rd_en (rd_en && sel),
            .grp   (grp),
            .wdata (wdata),
            .rdata (ch_rdata[i]),
            .irq   (irq[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (hit && ch_idx == CH_W'(i)) rdata = ch_rdata[i];
    end

    // R11: a misaligned address always reads 0
    a_r11_misaligned_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[1:0] != 2'b00) |-> (rdata == '0));
endmodule

// File: tb/tri_timer_unit_tb.sv
`timescale 1ns/1ps
module tri_timer_unit_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic        rd_en = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tri_timer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    localparam int GC = 0, GT = 1, GN = 2, GI = 3, GM = 4, GS = 7, GE = 8, GV = 9, GW = 10;

    function automatic logic [7:0] ra(int g, int ch);
        return 8'(g * 12 + ch * 4);
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(posedge clk); #1 wr_en = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
        @(posedge clk); #1 rd_en = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    // stepping model: returns {status, count} after a number of steps from 0
    function automatic logic [21:0] model(bit intm, bit dec, bit men,
        logic [15:0] iv, logic [15:0] m0, logic [15:0] m1, logic [15:0] m2, int steps);
        logic [15:0] lim, c;
        logic [5:0]  s;
        bit          w;
        lim = intm ? iv : 16'hFFFF;
        c = 0; s = 0;
        for (int k = 0; k < steps; k++) begin
            w = 0;
            if (dec) begin
                if (c == 0) begin c = lim; w = 1; end else c = c - 1;
            end else begin
                if (c >= lim) begin c = 0; w = 1; end else c = c + 1;
            end
            if (w) s |= intm ? 6'h01 : 6'h10;
            if (men && c == m0 && m0 <= lim) s |= 6'h02;
            if (men && c == m1 && m1 <= lim) s |= 6'h04;
            if (men && c == m2 && m2 <= lim) s |= 6'h08;
        end
        return {s, c};
    endfunction

    task automatic finish_run;
        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        idle(200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v, v2;
        logic [21:0] mr;
        void'($urandom(32'h5EED));
        idle(3);
        #1 rst_n = 1;

        // R3: reset state
        for (int c = 0; c < 3; c++) begin
            rd(ra(GT, c), v); chk("R3 ctrl reset", v, 32'h21);
            rd(ra(GN, c), v); chk("R3 count reset", v, 0);
        end
        chk("R3 irq reset", {29'd0, irq}, 0);

        // R10: masks and channel interleaving
        wr(ra(GI, 1), 32'hABCD1234); wr(ra(GI, 2), 32'h00005678);
        rd(ra(GI, 1), v); chk("R10 interval ch1", v, 32'h1234);
        rd(ra(GI, 2), v); chk("R10 interval ch2", v, 32'h5678);
        wr(ra(GC, 2), 32'hFFFFFFFF);
        rd(ra(GC, 2), v); chk("R10 clock ctrl mask", v, 32'h3F);
        wr(ra(GC, 2), 0);
        wr(ra(GE, 0), 32'hFF); rd(ra(GE, 0), v); chk("R10 enable mask", v, 32'h3F);
        wr(ra(GE, 0), 0);
        wr(ra(GV, 1), 32'hFF); rd(ra(GV, 1), v); chk("R10 event ctrl mask", v, 32'h07);
        wr(ra(GM + 2, 0), 32'h12345678); rd(ra(GM + 2, 0), v); chk("R10 compare3 mask", v, 32'h5678);

        // R11: event count, unmapped and misaligned read 0
        rd(ra(GW, 1), v); chk("R11 event count", v, 0);
        rd(8'h84, v); chk("R11 unmapped", v, 0);
        rd(8'h25, v); chk("R11 misaligned", v, 0);

        // R4: clear bit never stored
        wr(ra(GT, 0), 32'h13); rd(ra(GT, 0), v); chk("R4 clear bit reads 0", v, 32'h03);

        // R5/R6: down from zero wraps to 0xFFFF with overflow flag
        wr(ra(GT, 0), 32'h14); idle(1);
        rd(ra(GN, 0), v); chk("R5 down wrap", v, 32'hFFFF);
        rd(ra(GS, 0), v); chk("R6 overflow bit", v, 32'h10);

        // R2: stopped channel holds count
        wr(ra(GT, 0), 32'h05); rd(ra(GN, 0), v); idle(7); rd(ra(GN, 0), v2);
        chk("R2 hold while stopped", v2, v);
        // R11: count is read-only
        wr(ra(GN, 0), 32'h55); rd(ra(GN, 0), v2); chk("R11 count read-only", v2, v);

        // R1: prescaler N=1 gives one step per 4 clocks
        wr(ra(GC, 0), 32'h03); wr(ra(GT, 0), 32'h10); idle(40);
        rd(ra(GN, 0), v); chk("R1 prescaled steps", v, 10);
        wr(ra(GT, 0), 32'h11); wr(ra(GC, 0), 0);

        // R9/R8: interrupt and status clear, write ignored
        wr(ra(GT, 1), 32'h13); wr(ra(GI, 1), 3); wr(ra(GE, 1), 32'h01);
        wr(ra(GT, 1), 32'h02); idle(10);
        chk("R9 irq high", {31'd0, irq[1]}, 1);
        chk("R9 other irq low", {31'd0, irq[0] | irq[2]}, 0);
        wr(ra(GT, 1), 32'h03);
        wr(ra(GS, 1), 0);
        rd(ra(GS, 1), v); chk("R8 status write ignored", v, 32'h01);
        #1 chk("R9 irq low after read", {31'd0, irq[1]}, 0);
        rd(ra(GS, 1), v); chk("R8 cleared by read", v, 0);

        // R8: interval 0 wraps every step; event on read edge survives
        wr(ra(GT, 1), 32'h13); wr(ra(GI, 1), 0); wr(ra(GT, 1), 32'h02); idle(3);
        rd(ra(GS, 1), v); chk("R8 status before read", v, 32'h01);
        rd(ra(GS, 1), v); chk("R8 coincident event kept", v, 32'h01);
        wr(ra(GT, 1), 32'h03);

        // R7: compare above limit stays silent
        wr(ra(GT, 2), 32'h13); wr(ra(GI, 2), 10);
        wr(ra(GM, 2), 10); wr(ra(GM + 1, 2), 5); wr(ra(GM + 2, 2), 20);
        rd(ra(GS, 2), v);
        wr(ra(GT, 2), 32'h0A); idle(30); wr(ra(GT, 2), 32'h0B);
        rd(ra(GS, 2), v); chk("R7 compares and limit", v, 32'h07);

        // R5/R6/R7 random trials
        for (int t = 0; t < 24; t++) begin
            int ch, n;
            bit intm, dec, men;
            logic [15:0] iv, m0, m1, m2;
            ch = $urandom_range(0, 2); n = $urandom_range(1, 150);
            intm = 1'($urandom_range(0, 1)); dec = 1'($urandom_range(0, 1));
            men = 1'($urandom_range(0, 1));
            iv = 16'($urandom_range(0, 40)); m0 = 16'($urandom_range(0, 45));
            m1 = 16'($urandom_range(0, 45)); m2 = 16'($urandom_range(0, 45));
            wr(ra(GT, ch), 32'h11); wr(ra(GC, ch), 0); wr(ra(GI, ch), {16'd0, iv});
            wr(ra(GM, ch), {16'd0, m0}); wr(ra(GM + 1, ch), {16'd0, m1});
            wr(ra(GM + 2, ch), {16'd0, m2}); rd(ra(GS, ch), v);
            wr(ra(GT, ch), {28'd0, men, dec, intm, 1'b0});
            idle(n);
            rd(ra(GN, ch), v);
            mr = model(intm, dec, men, iv, m0, m1, m2, n);
            chk("R5 random count", v, {16'd0, mr[15:0]});
            rd(ra(GS, ch), v);
            mr = model(intm, dec, men, iv, m0, m1, m2, n + 1);
            chk("R6 R7 random status", v, {26'd0, mr[21:16]});
        end
        finish_run();
    end
endmodule